// File: doc/BRIEF.md
# Dual-Channel Interrupt Cause Controller

This block collects event pulses from two engine channels into one shared, sticky 32-bit cause register and gates them with a shared 32-bit mask register. Each channel owns one 16-bit half of both registers. A one-cycle pulse on an event input sets the matching cause bit, and the bit stays set until software clears it. Each channel drives its own interrupt line. The line is high while any cause bit in that channel's half is set and also enabled in the mask.

Software clears cause bits by writing zero to them. A one written to a cause bit leaves it as it was. A handler can therefore clear only the bits it has serviced by writing the inverse of that pattern, and events that arrive meanwhile are not lost. Reads return the whole 32-bit register, both halves included. Within each half, bits 0 to 7 hold events. Bits 8 to 15 are reserved: they never set and always read zero.

Top module: `dual_irq_cause`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the cause and mask registers read 0x00000000 and both irq lines are low.
- R2: A pulse on evt_pulse[16n+k], with k in 0..7, sets cause bit 16n+k at the next clock edge, and the bit stays set in later cycles until it is cleared. Within a half, k=0 is descriptor done, k=1 chain done, k=2 channel halted, k=3 address decode error, and k=4..7 are other error kinds.
- R3: A write with wr_en=1 and wr_sel=0 clears every cause bit whose wr_data bit is 0 and leaves every cause bit whose wr_data bit is 1 unchanged.
- R4: When an event pulse and a clearing cause write hit the same bit in the same cycle, the bit is set after that edge.
- R5: A write with wr_en=1 and wr_sel=1 loads the mask register with wr_data at bits 0..7 of each half. Without such a write, the mask keeps its value.
- R6: irq[n] is 1 exactly when some bit in bits 16n..16n+15 is set in both cause and mask. It follows the registers in the same cycle.
- R7: Events and writes aimed at one channel's half leave the other channel's half of cause unchanged.
- R8: Bits 8..15 of each half read 0 in both registers, whatever events or writes are applied.
- R9: rd_data shows the full 32-bit cause register when rd_sel=0 and the full 32-bit mask register when rd_sel=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 32 | Event pulses; bits [16n+15:16n] belong to channel n |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 cause, 1 mask |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 cause, 1 mask |
| rd_data | output | 32 | Selected register contents |
| irq | output | 2 | Per-channel interrupt lines |

## Verification
The assertions check on every cycle, bit by bit, the rules that need no history: an event sets its bit, a zero write clears the bit unless an event lands on it, a set bit only falls on a zero write, reserved bits stay zero, the mask changes only when written, and each irq line matches its half. Some behaviours only the bench scenarios can show. These are where each event code lands in the 32-bit map seen through the read port, that a write of all ones leaves every pending bit in place, that one channel's clear pattern leaves the other half alone, and irq behaviour across a sweep of single mask bits over a fully set cause register.

// File: rtl/irq_cause_pkg.sv
// Package: shared definitions for the dual-channel interrupt cause controller.
// Assumes each channel owns an equal-width half of the cause and mask registers.
package irq_cause_pkg;

    // Event bit positions within one channel's half (software decodes these)
    localparam int unsigned EV_DESC_DONE   = 0;
    localparam int unsigned EV_CHAIN_DONE  = 1;
    localparam int unsigned EV_HALTED      = 2;
    localparam int unsigned EV_ADDR_DECODE = 3;
    localparam int unsigned EV_ERR_PROT    = 4;
    localparam int unsigned EV_ERR_WRPROT  = 5;
    localparam int unsigned EV_ERR_OWNER   = 6;
    localparam int unsigned EV_ERR_PARITY  = 7;

    // Register selector used for both reads and writes
    typedef enum logic {
        SEL_CAUSE = 1'b0,
        SEL_MASK  = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/cause_slice.sv
// Module: cause_slice
// Sticky cause bits for one channel. Event pulses set bits; a write clears the
// bits whose data bit is zero and keeps those whose data bit is one. An event
// beats a clear on the same bit. Bits outside IMPL stay zero.
// Assumes events are single-cycle pulses from logic in the same clock domain.
module cause_slice #(
    parameter int unsigned           W    = 16,
    parameter logic [W-1:0]          IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cause_q
);

    logic [W-1:0] keep_mask;
    logic [W-1:0] cause_d;

    // Bits that survive this cycle's write (all survive when not written)
    always_comb begin
        keep_mask = wr_en ? wr_data : {W{1'b1}};
    end

    // Next cause: surviving bits plus new events, limited to implemented bits
    always_comb begin
        cause_d = ((cause_q & keep_mask) | evt) & IMPL;
    end

    // Cause register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= cause_d;
        end
    end

endmodule

// File: rtl/mask_slice.sv
// Module: mask_slice
// Interrupt enable bits for one channel. It loads on a write and holds otherwise.
// Bits outside IMPL are forced to zero.
module mask_slice #(
    parameter int unsigned  W    = 16,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] mask_q
);

    // Mask register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= wr_data & IMPL;
        end
    end

endmodule

// File: rtl/irq_reduce.sv
// Module: irq_reduce
// Combines one channel's cause and mask into its interrupt line.
// Purely combinational; the line follows the registers in the same cycle.
module irq_reduce #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] cause,
    input  logic [W-1:0] mask,
    output logic         irq
);

    // Any enabled pending bit raises the line
    always_comb begin
        irq = |(cause & mask);
    end

endmodule

// File: rtl/dual_irq_cause.sv
// Module: dual_irq_cause (top)
// Shared cause and mask registers for NUM_CH channels, each owning HALF_W bits
// at [HALF_W*n +: HALF_W]. Cause is cleared by writing zero. Reads return the
// full register selected by rd_sel.
// Assumes one write port driven by a simple strobe and combinational reads.
module dual_irq_cause
    import irq_cause_pkg::*;
#(
    parameter int unsigned       NUM_CH    = 2,
    parameter int unsigned       HALF_W    = 16,
    parameter logic [HALF_W-1:0] IMPL_MASK = 16'h00FF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*HALF_W-1:0] evt_pulse,
    input  logic                     wr_en,
    input  logic                     wr_sel,
    input  logic [NUM_CH*HALF_W-1:0] wr_data,
    input  logic                     rd_sel,
    output logic [NUM_CH*HALF_W-1:0] rd_data,
    output logic [NUM_CH-1:0]        irq
);

    localparam int unsigned REG_W = NUM_CH * HALF_W;

    logic             cause_wr;
    logic             mask_wr;
    logic [REG_W-1:0] cause_q;
    logic [REG_W-1:0] mask_q;

    // Decode the write strobe into the two register targets
    always_comb begin
        cause_wr = wr_en && (wr_sel == SEL_CAUSE);
        mask_wr  = wr_en && (wr_sel == SEL_MASK);
    end

    // One cause slice, mask slice and reducer per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        cause_slice #(
            .W    (HALF_W),
            .IMPL (IMPL_MASK)
        ) cause_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_pulse[ch*HALF_W +: HALF_W]),
            .wr_en   (cause_wr),
            .wr_data (wr_data[ch*HALF_W +: HALF_W]),
            .cause_q (cause_q[ch*HALF_W +: HALF_W])
        );

        mask_slice #(
            .W    (HALF_W),
            .IMPL (IMPL_MASK)
        ) mask_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (mask_wr),
            .wr_data (wr_data[ch*HALF_W +: HALF_W]),
            .mask_q  (mask_q[ch*HALF_W +: HALF_W])
        );

        irq_reduce #(
            .W (HALF_W)
        ) irq_i (
            .cause (cause_q[ch*HALF_W +: HALF_W]),
            .mask  (mask_q[ch*HALF_W +: HALF_W]),
            .irq   (irq[ch])
        );
    end

    // Read mux returning the full selected register
    always_comb begin
        rd_data = (rd_sel == SEL_MASK) ? mask_q : cause_q;
    end

endmodule

// File: rtl/dual_irq_cause_chk.sv
// Module: dual_irq_cause_chk
// Property checker bound to dual_irq_cause. Checks per-bit set, clear and
// hold rules, reserved bits, mask loading and the irq lines.
module dual_irq_cause_chk
    import irq_cause_pkg::*;
#(
    parameter int unsigned       NUM_CH    = 2,
    parameter int unsigned       HALF_W    = 16,
    parameter logic [HALF_W-1:0] IMPL_MASK = 16'h00FF
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH*HALF_W-1:0] evt_pulse,
    input logic                     wr_en,
    input logic                     wr_sel,
    input logic [NUM_CH*HALF_W-1:0] wr_data,
    input logic [NUM_CH-1:0]        irq,
    input logic [NUM_CH*HALF_W-1:0] cause_q,
    input logic [NUM_CH*HALF_W-1:0] mask_q
);

    localparam int unsigned      REG_W  = NUM_CH * HALF_W;
    localparam logic [REG_W-1:0] IMPL32 = {NUM_CH{IMPL_MASK}};

    logic cw;
    logic mw;
    assign cw = wr_en && (wr_sel == SEL_CAUSE);
    assign mw = wr_en && (wr_sel == SEL_MASK);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (cause_q == '0) && (mask_q == '0));

    // R5
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mw |=> mask_q == ($past(wr_data) & IMPL32));

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mw |=> $stable(mask_q));

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (IMPL_MASK[b % HALF_W]) begin : g_impl
            // R2
            evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
                evt_pulse[b] |=> cause_q[b]);

            // R4
            evt_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (evt_pulse[b] && cw && !wr_data[b]) |=> cause_q[b]);

            // R3
            zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cw && !wr_data[b] && !evt_pulse[b]) |=> !cause_q[b]);

            // R3
            sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cause_q[b] && !(cw && !wr_data[b])) |=> cause_q[b]);
        end else begin : g_rsvd
            // R8
            reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !cause_q[b] && !mask_q[b]);
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // R6
        irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[ch] == |(cause_q[ch*HALF_W +: HALF_W] & mask_q[ch*HALF_W +: HALF_W]));
    end

endmodule

bind dual_irq_cause dual_irq_cause_chk #(
    .NUM_CH    (NUM_CH),
    .HALF_W    (HALF_W),
    .IMPL_MASK (IMPL_MASK)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .irq       (irq),
    .cause_q   (cause_q),
    .mask_q    (mask_q)
);

// File: tb/dual_irq_cause_tb_top.sv
`timescale 1ns/1ps
// Bench for dual_irq_cause: single-bit sweeps, collision sweep, mask sweep and
// a pseudo-random phase. Expected values come from a model of the requirements.
module dual_irq_cause_tb_top;

    localparam logic [31:0] IMPL32 = 32'h00FF_00FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_pulse = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [1:0]  irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_c = '0;
    logic [31:0] exp_m = '0;

    always #2.5 clk = ~clk;

    dual_irq_cause dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    function automatic logic [1:0] exp_irq();
        logic [31:0] p;
        p = exp_c & exp_m;
        return {|p[31:16], |p[15:0]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Read both registers and the irq lines, compare with the model
    task automatic chk_all(input string req);
        @(negedge clk);
        rd_sel = 1'b0; #0.5;
        check(req, "cause", rd_data, exp_c);
        rd_sel = 1'b1; #0.5;
        check(req, "mask", rd_data, exp_m);
        check(req, "irq", {30'd0, irq}, {30'd0, exp_irq()});
        rd_sel = 1'b0;
    endtask

    // One clock cycle of stimulus, with the model updated from the requirements
    task automatic cyc(input logic [31:0] e, input logic w, input logic s,
                       input logic [31:0] d);
        @(negedge clk);
        evt_pulse = e; wr_en = w; wr_sel = s; wr_data = d;
        if (w && !s) exp_c = exp_c & d;          // R3 zero clears, one keeps
        if (w && s)  exp_m = d & IMPL32;         // R5
        exp_c = (exp_c | e) & IMPL32;            // R2, R4 event wins, R8
        @(posedge clk);
        #0.5;
        evt_pulse = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin : watchdog
        #(5.0 * 50000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_all("R1");

        // R5 / R8 mask write of all ones keeps only event bits
        cyc('0, 1'b1, 1'b1, 32'hFFFF_FFFF);
        chk_all("R5_R8");

        // R2 / R3 / R6 / R8 / R9 single-bit sweep over both halves
        for (int b = 0; b < 32; b++) begin
            cyc(32'd1 << b, 1'b0, 1'b0, '0);
            chk_all("R2_R6_R9");
            cyc('0, 1'b1, 1'b0, 32'hFFFF_FFFF);
            chk_all("R3_keep");
            cyc('0, 1'b1, 1'b0, ~(32'd1 << b));
            chk_all("R3_clear");
        end

        // R4 event and clear-all in the same cycle
        for (int b = 0; b < 32; b++) begin
            cyc(32'd1 << b, 1'b1, 1'b0, 32'h0000_0000);
            chk_all("R4");
        end
        cyc('0, 1'b1, 1'b0, '0);

        // R7 clearing one channel leaves the other half alone
        cyc(IMPL32, 1'b0, 1'b0, '0);
        cyc('0, 1'b1, 1'b0, 32'hFFFF_0000);
        chk_all("R7_ch0");
        cyc(32'h0000_0009, 1'b1, 1'b0, 32'h0000_FFFF);
        chk_all("R7_ch1");

        // R6 mask sweep over a fully set cause register
        cyc(IMPL32, 1'b0, 1'b0, '0);
        for (int b = 0; b < 32; b++) begin
            cyc('0, 1'b1, 1'b1, 32'd1 << b);
            chk_all("R6_mask");
        end
        cyc('0, 1'b1, 1'b1, '0);
        chk_all("R6_none");

        // R2 R3 R4 R5 pseudo-random mix
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(lfsr & {lfsr[7:0], lfsr[31:8]}, lfsr[3], lfsr[9],
                {lfsr[15:0], lfsr[31:16]} | 32'h1111_2222);
            chk_all("R2_R3_R4_R5_mix");
        end

        // R1 reset in the middle of activity
        cyc(IMPL32, 1'b1, 1'b1, 32'hFFFF_FFFF);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #0.5;
        rst_n = 1'b1;
        exp_c = '0; exp_m = '0;
        chk_all("R1_midrun");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule